// File: doc/BRIEF.md
# Adaptive Peak Level Slicer

This block turns a stream of signed samples from a filtered frequency discriminator into hard data bits. Two trackers follow the positive and the negative peaks of the signal. Their midpoint is the decision threshold, so a DC offset on the input cancels out. A sample below the threshold is sliced to 1, and a sample at or above it is sliced to 0.

An acquire control selects how the peaks are measured. While acquire is high, both peaks snap to every sample (clamp mode). After acquire drops, the trackers use a large attack step for a set number of bit strobes (fast mode). After that they settle into small attack and decay steps (averaging mode).

An active-low hold input freezes both peaks during a fade. Hold is ignored while the block is clamping. Slicing carries on during hold against the frozen threshold. Pulsing acquire high again for a number of bit periods restarts level measurement after a long fade.

The sample input uses a valid/ready handshake. The block never applies back-pressure: ready stays high, and every cycle with valid high moves one sample. The sliced bit leaves with a valid strobe and has no ready input, so the consumer must take it in the cycle it is shown.

Top module: `peak_slicer`

## Requirements
- R1: `in_ready_o` is always 1. Each cycle with `in_valid_i` high accepts one sample, and `out_valid_o` is high in exactly the cycle after each accepted sample.
- R2: If a sample is accepted while `acq_i` is high or the mode is clamp, both peaks equal that sample on the next cycle, whatever the value of `hold_n_i`.
- R3: Mode codes are clamp=0, fast=1 and averaging=2. A cycle with `acq_i` high puts the mode at clamp on the next cycle. A clamp cycle with `acq_i` low moves the mode to fast on the next cycle.
- R4: Fast mode counts the cycles with `bit_stb_i` high, starting at zero on entry. The FAST_BITS-th strobe moves the mode to averaging on the next cycle. Averaging mode holds until `acq_i` rises.
- R5: When tracking (no clamp, `hold_n_i` high), each accepted sample moves each peak toward the sample. If the sample lies beyond the peak (above it for the positive peak, below it for the negative peak), the step is the distance shifted right by the attack amount. Otherwise the step is the distance shifted right by the decay amount. With no accepted sample, the peaks do not change.
- R6: Fast mode uses FAST_ATK_SH and FAST_DEC_SH as the shift amounts. Averaging mode uses AVG_ATK_SH and AVG_DEC_SH.
- R7: While `hold_n_i` is low and the block is not clamping, accepted samples leave both peaks unchanged.
- R8: `thr_o` equals floor((pos_pk_o + neg_pk_o) / 2). The sum is formed with one extra bit, so it cannot overflow.
- R9: `out_bit_o` is 1 when the accepted sample was below the threshold in force in its acceptance cycle, and 0 otherwise. This holds during hold as well.
- R10: After reset the mode is clamp, both peaks and the threshold are 0, and `out_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Sample valid |
| in_ready_o | output | 1 | Sample ready, always 1 |
| in_sample_i | input | DW | Signed sample |
| bit_stb_i | input | 1 | One pulse per bit period |
| acq_i | input | 1 | Acquire: clamp and restart measurement |
| hold_n_i | input | 1 | Active-low freeze of the peaks |
| pos_pk_o | output | DW | Positive peak, signed |
| neg_pk_o | output | DW | Negative peak, signed |
| thr_o | output | DW | Decision threshold, signed |
| out_valid_o | output | 1 | Sliced bit valid |
| out_bit_o | output | 1 | Sliced data bit |
| mode_o | output | 2 | Measuring mode |

## Verification
Peaks, mode and the sliced bit are registered, so each is due one clock edge after the inputs that cause it. The threshold follows the peaks combinationally and is due in the same cycle as they are. The bench drives every input on the falling edge and computes the next state from its own model. It then waits for the rising edge plus a short delay before comparing all outputs, so each result is checked in exactly the cycle it is due. The slicing decision is predicted from the threshold the model held before that edge.

// File: rtl/peak_slicer_pkg.sv
package peak_slicer_pkg;
  typedef enum logic [1:0] {
    MODE_CLAMP = 2'd0,
    MODE_FAST  = 2'd1,
    MODE_AVG   = 2'd2
  } lvl_mode_e;
endpackage

// File: rtl/peak_mode_ctrl.sv
module peak_mode_ctrl
  import peak_slicer_pkg::*;
#(
  parameter int FAST_BITS = 30
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      acq_i,
  input  logic      bit_stb_i,
  output lvl_mode_e mode_o
);
  localparam int CW = $clog2(FAST_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(FAST_BITS - 1);

  lvl_mode_e     mode_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_CLAMP;
      cnt_q  <= '0;
    end else if (acq_i) begin
      mode_q <= MODE_CLAMP;
      cnt_q  <= '0;
    end else begin
      case (mode_q)
        MODE_CLAMP: begin
          mode_q <= MODE_FAST;
          cnt_q  <= '0;
        end
        MODE_FAST: begin
          if (bit_stb_i) begin
            if (cnt_q == LAST) mode_q <= MODE_AVG;
            else               cnt_q  <= cnt_q + 1'b1;
          end
        end
        MODE_AVG: mode_q <= MODE_AVG;
        default:  mode_q <= MODE_CLAMP;
      endcase
    end
  end

  assign mode_o = mode_q;

  // R3
  acq_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acq_i |=> mode_q == MODE_CLAMP);
  // R3
  clamp_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_CLAMP && !acq_i) |=> mode_q == MODE_FAST);
  // R4
  avg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_AVG && !acq_i) |=> mode_q == MODE_AVG);
  // R4
  fast_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_FAST && !acq_i && !bit_stb_i) |=> mode_q == MODE_FAST);
endmodule

// File: rtl/peak_tracker.sv
module peak_tracker #(
  parameter int DW          = 12,
  parameter bit IS_POS      = 1'b1,
  parameter int FAST_ATK_SH = 1,
  parameter int FAST_DEC_SH = 5,
  parameter int AVG_ATK_SH  = 4,
  parameter int AVG_DEC_SH  = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_i,
  input  logic                 clamp_i,
  input  logic                 freeze_i,
  input  logic                 fast_i,
  input  logic signed [DW-1:0] x_i,
  output logic signed [DW-1:0] pk_o
);
  localparam int EW = DW + 1;

  logic signed [DW-1:0] pk_q;
  logic signed [EW-1:0] xe, pe, gap, nxt_w;
  logic        [EW-1:0] mag, step;
  logic                 attack, up;

  assign xe = EW'(x_i);
  assign pe = EW'(pk_q);

  generate
    if (IS_POS) begin : g_pos
      assign gap = xe - pe;
      assign up  = attack;
    end else begin : g_neg
      assign gap = pe - xe;
      assign up  = !attack;
    end
  endgenerate

  always_comb begin
    attack = gap > 0;
    mag    = attack ? gap : -gap;
    if (attack) step = fast_i ? (mag >> FAST_ATK_SH) : (mag >> AVG_ATK_SH);
    else        step = fast_i ? (mag >> FAST_DEC_SH) : (mag >> AVG_DEC_SH);
    nxt_w  = up ? (pe + $signed(step)) : (pe - $signed(step));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pk_q <= '0;
    else if (upd_i && clamp_i)  pk_q <= x_i;
    else if (upd_i && !freeze_i) pk_q <= nxt_w[DW-1:0];
  end

  assign pk_o = pk_q;

  // R2
  clamp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && clamp_i) |=> pk_o == $past(x_i));
  // R7
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && freeze_i && !clamp_i) |=> $stable(pk_o));
  // R5
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(pk_o));
  // R5
  toward_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && !clamp_i && !freeze_i) |=>
      (($past(pk_o) <= pk_o && pk_o <= $past(x_i)) ||
       ($past(x_i) <= pk_o && pk_o <= $past(pk_o))));
endmodule

// File: rtl/peak_slicer.sv
module peak_slicer
  import peak_slicer_pkg::*;
#(
  parameter int DW          = 12,
  parameter int FAST_BITS   = 30,
  parameter int FAST_ATK_SH = 1,
  parameter int FAST_DEC_SH = 5,
  parameter int AVG_ATK_SH  = 4,
  parameter int AVG_DEC_SH  = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic signed [DW-1:0] in_sample_i,
  input  logic                 bit_stb_i,
  input  logic                 acq_i,
  input  logic                 hold_n_i,
  output logic signed [DW-1:0] pos_pk_o,
  output logic signed [DW-1:0] neg_pk_o,
  output logic signed [DW-1:0] thr_o,
  output logic                 out_valid_o,
  output logic                 out_bit_o,
  output logic [1:0]           mode_o
);
  localparam int EW = DW + 1;

  lvl_mode_e            mode;
  logic                 accept, clamp, fast;
  logic signed [EW-1:0] pk_sum;
  logic                 vld_q, bit_q;

  assign in_ready_o = 1'b1;
  assign accept     = in_valid_i && in_ready_o;
  assign clamp      = acq_i || (mode == MODE_CLAMP);
  assign fast       = (mode == MODE_FAST);

  peak_mode_ctrl #(.FAST_BITS(FAST_BITS)) u_mode (
    .clk(clk), .rst_n(rst_n), .acq_i(acq_i), .bit_stb_i(bit_stb_i), .mode_o(mode)
  );

  for (genvar g = 0; g < 2; g++) begin : g_trk
    logic signed [DW-1:0] pk;
    peak_tracker #(
      .DW(DW), .IS_POS(g == 0),
      .FAST_ATK_SH(FAST_ATK_SH), .FAST_DEC_SH(FAST_DEC_SH),
      .AVG_ATK_SH(AVG_ATK_SH), .AVG_DEC_SH(AVG_DEC_SH)
    ) u_trk (
      .clk(clk), .rst_n(rst_n), .upd_i(accept), .clamp_i(clamp),
      .freeze_i(!hold_n_i), .fast_i(fast), .x_i(in_sample_i), .pk_o(pk)
    );
  end

  assign pos_pk_o = g_trk[0].pk;
  assign neg_pk_o = g_trk[1].pk;

  assign pk_sum = EW'(pos_pk_o) + EW'(neg_pk_o);
  assign thr_o  = pk_sum[EW-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      vld_q <= accept;
      if (accept) bit_q <= (in_sample_i < thr_o);
    end
  end

  assign out_valid_o = vld_q;
  assign out_bit_o   = bit_q;
  assign mode_o      = mode;

  // R1
  out_valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> out_valid_o);
  // R1
  out_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> !out_valid_o);
  // R8
  thr_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_pk_o >= neg_pk_o) |-> (thr_o >= neg_pk_o && thr_o <= pos_pk_o));
  // R9
  slice_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_sample_i >= thr_o) |=> !out_bit_o);
endmodule

// File: tb/peak_slicer_bench.sv
module peak_slicer_bench;
  localparam int DW = 12;
  localparam int NB = 30;
  localparam int FA = 1, FD = 5, AA = 4, AD = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, bit_stb = 1'b0, acq = 1'b0, hold_n = 1'b1;
  logic [DW-1:0] sample = '0;
  logic in_ready, out_valid, out_bit;
  logic [DW-1:0] pos_pk, neg_pk, thr;
  logic [1:0] mode;

  int total = 0, bad = 0;
  int m_mode = 0, m_cnt = 0, m_pos = 0, m_neg = 0, m_bit = 0;

  always #4 clk = ~clk;

  peak_slicer u_peak_slicer (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_sample_i(sample), .bit_stb_i(bit_stb), .acq_i(acq), .hold_n_i(hold_n),
    .pos_pk_o(pos_pk), .neg_pk_o(neg_pk), .thr_o(thr), .out_valid_o(out_valid),
    .out_bit_o(out_bit), .mode_o(mode)
  );

  function automatic int sx(logic [DW-1:0] v);
    return int'($signed(v));
  endfunction

  function automatic int next_peak(int pk, int x, bit is_pos, bit f);
    if (is_pos) begin
      if (x > pk) return pk + ((x - pk) >> (f ? FA : AA));
      return pk - ((pk - x) >> (f ? FD : AD));
    end
    if (x < pk) return pk - ((pk - x) >> (f ? FA : AA));
    return pk + ((x - pk) >> (f ? FD : AD));
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(bit v, int x, bit a, bit h, bit s);
    string ptag;
    int thr_now;
    bit clampc;
    @(negedge clk);
    in_valid = v; sample = DW'(x); acq = a; hold_n = h; bit_stb = s;
    thr_now = (m_pos + m_neg) >>> 1;
    clampc  = a || (m_mode == 0);
    ptag = clampc ? "R2 clamp" : (!h ? "R7 hold" : (m_mode == 1 ? "R5 fast track" : "R6 avg track"));
    if (v) begin
      m_bit = (x < thr_now) ? 1 : 0;
      if (clampc) begin m_pos = x; m_neg = x; end
      else if (h) begin
        m_pos = next_peak(m_pos, x, 1'b1, m_mode == 1);
        m_neg = next_peak(m_neg, x, 1'b0, m_mode == 1);
      end
    end
    if (a) begin m_mode = 0; m_cnt = 0; end
    else if (m_mode == 0) begin m_mode = 1; m_cnt = 0; end
    else if (m_mode == 1 && s) begin
      if (m_cnt == NB - 1) m_mode = 2; else m_cnt++;
    end
    @(posedge clk); #2;
    chk("R1 ready", int'(in_ready), 1);
    chk("R1 out_valid", int'(out_valid), int'(v));
    chk(m_mode == 2 ? "R4 mode" : "R3 mode", int'(mode), m_mode);
    chk({ptag, " pos"}, sx(pos_pk), m_pos);
    chk({ptag, " neg"}, sx(neg_pk), m_neg);
    chk("R8 thr", sx(thr), (m_pos + m_neg) >>> 1);
    if (v) chk(h ? "R9 bit" : "R9 bit in hold", int'(out_bit), m_bit);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd589));
    repeat (3) @(posedge clk);
    #2;
    chk("R10 mode", int'(mode), 0);
    chk("R10 pos", sx(pos_pk), 0);
    chk("R10 neg", sx(neg_pk), 0);
    chk("R10 thr", sx(thr), 0);
    chk("R10 out_valid", int'(out_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    // R2: clamp with hold low is still a clamp
    cyc(1, 500, 1, 0, 0);
    cyc(1, -300, 1, 0, 0);
    cyc(0, 0, 1, 1, 0);
    // R3 R5 R4: leave acquire, fast tracking, then averaging after NB strobes
    for (int i = 0; i < 160; i++)
      cyc(1, (i % 8 < 4) ? 1000 : -1000, 0, 1, (i % 4) == 3);
    // R6 R9: full-scale extremes in averaging mode
    for (int i = 0; i < 40; i++)
      cyc(1, (i % 2) ? 2047 : -2048, 0, 1, 0);
    // R7 R9: hold freezes peaks, slicing goes on
    for (int i = 0; i < 50; i++)
      cyc(($urandom % 4) != 0, int'($urandom % 4096) - 2048, 0, 0, 0);
    // R2: acquire pulse overrides hold, then re-acquire
    for (int i = 0; i < 15; i++) cyc(1, 300 + i, 1, 0, (i % 4) == 0);
    for (int i = 0; i < 3000; i++) begin
      int x;
      x = int'($urandom % 1600) - 700;
      cyc(($urandom % 5) != 0, x, ($urandom % 100) == 0,
          ($urandom % 10) != 0, ($urandom % 8) == 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule